// File: doc/BRIEF.md
# HS400 Mode-Switch Sequencer

This block is the control state machine inside an eMMC host controller that moves an already-initialised card (running legacy timings) into HS400 dual-data-rate operation. On a `start` pulse it selects the card, inspects two Extended CSD bytes through a byte-lookup port, and then issues a chain of SWITCH register writes. Between these writes it asks an external tuning block for a tuning run. It also steers the PHY clock-select and bus-mode outputs, so that each timing change on the card is followed by the matching change on the host side.

Every SWITCH is followed by a wait for the card to release busy and by a status poll. A failed command, a failed tuning run, a switch-error bit in the polled status, or a wait that runs past a cycle limit leaves the block in a sticky error state. A strap selects a shorter ordering for older cards, in which tuning is followed directly by the HS400 write. Another input lets the driver-strength check be skipped when the default output strength is acceptable.

Top module: `hs400_switch_seq`

## Requirements
- R1: After `start` the first command is index 7 with argument `{rca, 16'h0000}`. The block then reads Extended CSD byte 196 (`ecsd_rd` high, `ecsd_addr`=196), optionally reads byte 197, and only then issues its first index-6 command.
- R2: HS400 is accepted when byte 196 has bit 6 or bit 7 set. Otherwise `unsupported` rises and no index-6 command is ever issued. At most one of `done`, `unsupported` and `error` is high at a time.
- R3: With `skip_drv_rd`=0, byte 197 is read once, and the block stops in `unsupported` unless `drv_sel[3]`=0 and bit `drv_sel[2:0]` of byte 197 is set. With `skip_drv_rd`=1, byte 197 is never read and the strength field written is 0.
- R4: Every index-6 argument is `{6'b0, 2'b11, byte_index[7:0], value[7:0], 8'h00}`. The HS_TIMING (index 185) value is `{strength[3:0], timing[3:0]}`. The BUS_WIDTH (index 183) value is 8'h06.
- R5: The first write is HS_TIMING with timing 2. Once its status poll succeeds, `clk_sel` becomes 2 (target rate) and `phy_timing` becomes 2. `tune_req` is then held high until `tune_done`, and `tune_req` is high only while `clk_sel`=2.
- R6: With `legacy_seq`=0, tuning is followed by three writes in this order: HS_TIMING timing 1, then BUS_WIDTH 8'h06, then HS_TIMING timing 3. After the timing-1 write `clk_sel` becomes 1 (52 MHz or below), so the later writes are issued at `clk_sel`=1. After the bus-width write `ddr8` becomes 1.
- R7: After the timing-3 write completes, `clk_sel`=2, `ddr8`=1, `phy_timing`=3 and `done`=1.
- R8: With `legacy_seq`=1, tuning is followed directly by HS_TIMING timing 3, issued at `clk_sel`=2, with no timing-1 or bus-width writes.
- R9: After each index-6 command completes, the block waits for `card_busy` low and then issues index 13 with argument `{rca, 16'h0000}`. No index-13 command is issued while `card_busy` is high.
- R10: Any of the following sets `error`: `cmd_err` on a completing command, `tune_err` with `tune_done`, bit 7 (switch error) of the index-13 response, or a wait longer than `TMO_CYCLES`. `error` then holds until reset or a new `start`, and `start` clears all result flags.
- R11: `clk_sel`, `ddr8` and `phy_timing` do not change while a command is outstanding. Each command is issued at the clock setting listed in R5 to R8, and index 7 and the first write with its poll are issued at `clk_sel`=0.
- R12: During and after reset, `clk_sel`=0, `ddr8`=0, `phy_timing`=0, and `cmd_start`, `tune_req`, `done`, `unsupported` and `error` are all 0. A reset in the middle of a run returns the block to this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a switch run (accepted when not running) |
| legacy_seq | input | 1 | Use the short ordering after tuning |
| skip_drv_rd | input | 1 | Skip the driver-strength read, write strength 0 |
| drv_sel | input | 4 | Requested driver strength |
| rca | input | 16 | Relative card address |
| cmd_idx | output | 6 | Command index to the command engine |
| cmd_arg | output | 32 | Command argument |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_done | input | 1 | Command completed (response valid) |
| cmd_err | input | 1 | Command failed (with cmd_done) |
| cmd_resp | input | 32 | Response word |
| card_busy | input | 1 | Card holds DAT0 busy |
| ecsd_rd | output | 1 | Extended CSD lookup in use this cycle |
| ecsd_addr | output | 9 | Extended CSD byte index |
| ecsd_data | input | 8 | Looked-up byte (same cycle) |
| tune_req | output | 1 | Tuning request, held until tune_done |
| tune_done | input | 1 | Tuning finished |
| tune_err | input | 1 | Tuning failed (with tune_done) |
| clk_sel | output | 2 | 0 legacy, 1 at most 52 MHz, 2 target rate |
| ddr8 | output | 1 | PHY in 8-bit dual-data-rate mode |
| phy_timing | output | 2 | Timing interface now in force on the card |
| done | output | 1 | HS400 reached |
| unsupported | output | 1 | Card or strength not supported |
| error | output | 1 | Sticky failure |

## Verification
The switch path is tried with several card types and option settings: bit 6 alone, bit 7 alone, neither bit set, a strength the card cannot drive, the skip option and the short ordering. Taken together, these separate the decision on byte 196, the decision on byte 197 and the two post-tuning orderings. Each run compares the full command log against an expected list built from the requirements, including the clock setting at each issue, so a wrong order, a wrong argument field or a clock change at the wrong moment shows up at a specific command. Fault runs inject a status switch error, a tuning failure, a card stuck busy and a rejected select command. Each fault must end in an error that persists, and a reset during tuning must restore the idle outputs.

// File: rtl/hs400_seq_pkg.sv
// Package: shared types and constants for the HS400 switch sequencer.
// Assumes byte indices and timing codes fixed by the card's register layout.
package hs400_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL, S_RD_TYPE, S_RD_DRV, S_SW_HS200, S_TUNE,
        S_SW_HS, S_SW_BW, S_SW_HS400, S_DONE, S_UNSUP, S_ERR
    } step_t;

    typedef enum logic [2:0] {
        PH_ISSUE, PH_WAIT_CMD, PH_BUSY, PH_STAT_ISSUE, PH_STAT_WAIT
    } phase_t;

    localparam logic [7:0] IDX_HS_TIMING = 8'd185;
    localparam logic [7:0] IDX_BUS_WIDTH = 8'd183;
    localparam logic [8:0] IDX_DEV_TYPE  = 9'd196;
    localparam logic [8:0] IDX_DRV_CAPS  = 9'd197;
    localparam logic [7:0] BW_DDR_X8     = 8'h06;

    localparam logic [3:0] TI_HS     = 4'd1;
    localparam logic [3:0] TI_HS200  = 4'd2;
    localparam logic [3:0] TI_HS400  = 4'd3;

    localparam logic [1:0] CLK_LEGACY = 2'd0;
    localparam logic [1:0] CLK_HS52   = 2'd1;
    localparam logic [1:0] CLK_TARGET = 2'd2;

    localparam logic [5:0] CMD_SELECT = 6'd7;
    localparam logic [5:0] CMD_SWITCH = 6'd6;
    localparam logic [5:0] CMD_STATUS = 6'd13;
    localparam int unsigned SWITCH_ERR_BIT = 7;

    // Builds a write-byte SWITCH argument.
    function automatic logic [31:0] sw_arg(input logic [7:0] idx, input logic [7:0] val);
        return {6'b0, 2'b11, idx, val, 8'h00};
    endfunction

endpackage

// File: rtl/hs400_wait_timer.sv
// Module: counts cycles while a wait is in progress and flags expiry.
// Assumes run drops for at least one cycle between separate waits.
module hs400_wait_timer #(
    parameter int unsigned LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    // Count wait cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (!run)      cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LIM);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM); // R10
endmodule

// File: rtl/hs400_cmd_frame.sv
// Module: forms command index and argument from the current step and phase.
// Assumes status phases always use the status command; purely combinational.
module hs400_cmd_frame
    import hs400_seq_pkg::*;
(
    input  step_t       st,
    input  phase_t      ph,
    input  logic [15:0] rca,
    input  logic [3:0]  strength,
    output logic [5:0]  idx,
    output logic [31:0] arg
);
    // Select the command for the step or status poll.
    always_comb begin
        idx = '0;
        arg = '0;
        if (ph == PH_STAT_ISSUE || ph == PH_STAT_WAIT) begin
            idx = CMD_STATUS;
            arg = {rca, 16'h0000};
        end else begin
            unique case (st)
                S_SEL:      begin idx = CMD_SELECT; arg = {rca, 16'h0000}; end
                S_SW_HS200: begin idx = CMD_SWITCH; arg = sw_arg(IDX_HS_TIMING, {strength, TI_HS200}); end
                S_SW_HS:    begin idx = CMD_SWITCH; arg = sw_arg(IDX_HS_TIMING, {strength, TI_HS}); end
                S_SW_BW:    begin idx = CMD_SWITCH; arg = sw_arg(IDX_BUS_WIDTH, BW_DDR_X8); end
                S_SW_HS400: begin idx = CMD_SWITCH; arg = sw_arg(IDX_HS_TIMING, {strength, TI_HS400}); end
                default:    begin idx = '0; arg = '0; end
            endcase
        end
    end
endmodule

// File: rtl/hs400_switch_seq.sv
// Module: walks an initialised card into HS400 through select, capability
// reads, SWITCH writes with busy/status waits, and a tuning request.
// Assumes a same-cycle Extended CSD lookup and a command engine that reports
// card_busy valid in the cycle it raises cmd_done.
module hs400_switch_seq
    import hs400_seq_pkg::*;
#(
    parameter int unsigned TMO_CYCLES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        legacy_seq,
    input  logic        skip_drv_rd,
    input  logic [3:0]  drv_sel,
    input  logic [15:0] rca,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    output logic        cmd_start,
    input  logic        cmd_done,
    input  logic        cmd_err,
    input  logic [31:0] cmd_resp,
    input  logic        card_busy,
    output logic        ecsd_rd,
    output logic [8:0]  ecsd_addr,
    input  logic [7:0]  ecsd_data,
    output logic        tune_req,
    input  logic        tune_done,
    input  logic        tune_err,
    output logic [1:0]  clk_sel,
    output logic        ddr8,
    output logic [1:0]  phy_timing,
    output logic        done,
    output logic        unsupported,
    output logic        error
);
    step_t      st;
    phase_t     ph;
    logic [3:0] strength_q;
    logic       skip_q, legacy_q;
    logic       is_cmd_st, active, waiting, tmo;
    logic       unused_resp_bits;

    assign unused_resp_bits = ^{cmd_resp[31:SWITCH_ERR_BIT+1], cmd_resp[SWITCH_ERR_BIT-1:0]};

    assign is_cmd_st = st inside {S_SEL, S_SW_HS200, S_SW_HS, S_SW_BW, S_SW_HS400};
    assign active    = is_cmd_st || st == S_TUNE;
    assign waiting   = active && (ph inside {PH_WAIT_CMD, PH_BUSY, PH_STAT_WAIT});
    assign cmd_start = is_cmd_st && (ph == PH_ISSUE || ph == PH_STAT_ISSUE);
    assign tune_req  = (st == S_TUNE) && (ph == PH_WAIT_CMD);
    assign ecsd_rd   = (st == S_RD_TYPE) || (st == S_RD_DRV);
    assign ecsd_addr = (st == S_RD_DRV) ? IDX_DRV_CAPS : IDX_DEV_TYPE;

    hs400_wait_timer #(.LIMIT(TMO_CYCLES)) tmr_i (
        .clk(clk), .rst_n(rst_n), .run(waiting), .expired(tmo)
    );

    hs400_cmd_frame frame_i (
        .st(st), .ph(ph), .rca(rca), .strength(strength_q),
        .idx(cmd_idx), .arg(cmd_arg)
    );

    // Step sequencing, result flags and PHY mode outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; ph <= PH_ISSUE;
            clk_sel <= CLK_LEGACY; ddr8 <= 1'b0; phy_timing <= 2'd0;
            done <= 1'b0; unsupported <= 1'b0; error <= 1'b0;
            strength_q <= '0; skip_q <= 1'b0; legacy_q <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE, S_DONE, S_UNSUP, S_ERR: begin
                    if (start) begin
                        st <= S_SEL; ph <= PH_ISSUE;
                        done <= 1'b0; unsupported <= 1'b0; error <= 1'b0;
                        clk_sel <= CLK_LEGACY; ddr8 <= 1'b0; phy_timing <= 2'd0;
                        skip_q <= skip_drv_rd; legacy_q <= legacy_seq;
                        strength_q <= skip_drv_rd ? 4'd0 : drv_sel;
                    end
                end
                S_RD_TYPE: begin
                    if (ecsd_data[7:6] != 2'b00) st <= skip_q ? S_SW_HS200 : S_RD_DRV;
                    else begin st <= S_UNSUP; unsupported <= 1'b1; end
                end
                S_RD_DRV: begin
                    if (!strength_q[3] && ecsd_data[strength_q[2:0]]) st <= S_SW_HS200;
                    else begin st <= S_UNSUP; unsupported <= 1'b1; end
                end
                S_TUNE: begin
                    if (ph == PH_ISSUE) ph <= PH_WAIT_CMD;
                    else if (tmo || (tune_done && tune_err)) begin
                        st <= S_ERR; ph <= PH_ISSUE; error <= 1'b1;
                    end else if (tune_done) begin
                        st <= legacy_q ? S_SW_HS400 : S_SW_HS; ph <= PH_ISSUE;
                    end
                end
                default: begin
                    if (tmo) begin
                        st <= S_ERR; ph <= PH_ISSUE; error <= 1'b1;
                    end else begin
                        unique case (ph)
                            PH_ISSUE:      ph <= PH_WAIT_CMD;
                            PH_WAIT_CMD: if (cmd_done) begin
                                if (cmd_err) begin
                                    st <= S_ERR; ph <= PH_ISSUE; error <= 1'b1;
                                end else if (st == S_SEL) begin
                                    st <= S_RD_TYPE; ph <= PH_ISSUE;
                                end else ph <= PH_BUSY;
                            end
                            PH_BUSY:       if (!card_busy) ph <= PH_STAT_ISSUE;
                            PH_STAT_ISSUE: ph <= PH_STAT_WAIT;
                            PH_STAT_WAIT: if (cmd_done) begin
                                ph <= PH_ISSUE;
                                if (cmd_err || cmd_resp[SWITCH_ERR_BIT]) begin
                                    st <= S_ERR; error <= 1'b1;
                                end else begin
                                    unique case (st)
                                        S_SW_HS200: begin
                                            st <= S_TUNE; clk_sel <= CLK_TARGET; phy_timing <= 2'd2;
                                        end
                                        S_SW_HS: begin
                                            st <= S_SW_BW; clk_sel <= CLK_HS52; phy_timing <= 2'd1;
                                        end
                                        S_SW_BW:  begin st <= S_SW_HS400; ddr8 <= 1'b1; end
                                        default: begin
                                            st <= S_DONE; done <= 1'b1; ddr8 <= 1'b1;
                                            clk_sel <= CLK_TARGET; phy_timing <= 2'd3;
                                        end
                                    endcase
                                end
                            end
                            default: ph <= PH_ISSUE;
                        endcase
                    end
                end
            endcase
        end
    end

    AST_STATUS_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_idx == CMD_STATUS) |-> !card_busy); // R9
    AST_SWITCH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_idx == CMD_SWITCH) |-> (cmd_arg[31:24] == 8'h03 && cmd_arg[7:0] == 8'h00)); // R4
    AST_TUNE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        tune_req |-> clk_sel == CLK_TARGET); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph == PH_WAIT_CMD || ph == PH_STAT_WAIT) && is_cmd_st && !cmd_done)
        |=> ($stable(clk_sel) && $stable(ddr8) && $stable(phy_timing))); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error); // R10
    AST_DONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clk_sel == CLK_TARGET && ddr8 && phy_timing == 2'd3)); // R7
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, unsupported, error})); // R2
    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start); // R1
endmodule

// File: tb/hs400_switch_seq_tb_top.sv
module hs400_switch_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 300;
    localparam logic [15:0] RCA = 16'h5A21;

    typedef struct packed {
        logic [7:0] dev;
        logic [7:0] caps;
        logic [3:0] drv;
        logic       skip;
        logic       legacy;
        logic [2:0] fault;   // 0 none, 1 status switch error, 2 tuning fail, 3 stuck busy, 4 select rejected
        logic [1:0] outcome; // 0 done, 1 unsupported, 2 error
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h40, 8'h01, 4'd0, 1'b0, 1'b0, 3'd0, 2'd0},
        '{8'h80, 8'h0F, 4'd3, 1'b0, 1'b1, 3'd0, 2'd0},
        '{8'h3F, 8'hFF, 4'd0, 1'b0, 1'b0, 3'd0, 2'd1},
        '{8'hC0, 8'h01, 4'd2, 1'b0, 1'b0, 3'd0, 2'd1},
        '{8'h40, 8'h00, 4'd5, 1'b1, 1'b0, 3'd0, 2'd0},
        '{8'h40, 8'h01, 4'd0, 1'b0, 1'b0, 3'd1, 2'd2},
        '{8'h40, 8'h01, 4'd0, 1'b0, 1'b0, 3'd2, 2'd2},
        '{8'h40, 8'h01, 4'd0, 1'b0, 1'b0, 3'd3, 2'd2},
        '{8'h40, 8'h01, 4'd0, 1'b0, 1'b0, 3'd4, 2'd2}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, legacy_seq = 1'b0, skip_drv_rd = 1'b0;
    logic [3:0] drv_sel = '0;
    logic [5:0] cmd_idx; logic [31:0] cmd_arg; logic cmd_start;
    logic cmd_done = 1'b0, cmd_err = 1'b0, card_busy = 1'b0;
    logic [31:0] cmd_resp = '0;
    logic ecsd_rd; logic [8:0] ecsd_addr; logic [7:0] ecsd_data;
    logic tune_req, tune_done = 1'b0, tune_err = 1'b0;
    logic [1:0] clk_sel, phy_timing; logic ddr8, done, unsupported, error;

    logic [7:0] dev_type = '0, drv_caps = '0;
    int fault = 0, total = 0, bad = 0;
    int log_n = 0, rd197 = 0, busy_at_stat = 0, lat_cnt = 0, busy_cnt = 0, tune_cnt = 0;
    logic stuck = 1'b0; logic [5:0] pend_idx = '0; logic [1:0] tune_clk = 2'd3;
    logic [5:0] log_idx [16]; logic [31:0] log_arg [16]; logic [1:0] log_clk [16];
    logic [5:0] exp_idx [16]; logic [31:0] exp_arg [16]; logic [1:0] exp_clk [16];
    int exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ecsd_data = (ecsd_addr == 9'd196) ? dev_type : (ecsd_addr == 9'd197) ? drv_caps : 8'h00;

    hs400_switch_seq #(.TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .legacy_seq(legacy_seq),
        .skip_drv_rd(skip_drv_rd), .drv_sel(drv_sel), .rca(RCA),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_start(cmd_start),
        .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_resp(cmd_resp),
        .card_busy(card_busy), .ecsd_rd(ecsd_rd), .ecsd_addr(ecsd_addr),
        .ecsd_data(ecsd_data), .tune_req(tune_req), .tune_done(tune_done),
        .tune_err(tune_err), .clk_sel(clk_sel), .ddr8(ddr8), .phy_timing(phy_timing),
        .done(done), .unsupported(unsupported), .error(error)
    );

    // Card and engine model, acting on falling edges.
    initial forever begin
        @(negedge clk);
        cmd_done = 1'b0; cmd_err = 1'b0; tune_done = 1'b0; tune_err = 1'b0;
        if (!rst_n) begin
            lat_cnt = 0; busy_cnt = 0; tune_cnt = 0; card_busy = 1'b0;
        end else begin
            if (busy_cnt > 0) busy_cnt--;
            card_busy = stuck || (busy_cnt > 0);
            if (ecsd_rd && ecsd_addr == 9'd197) rd197++;
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    cmd_done = 1'b1;
                    cmd_err  = (fault == 4) && (pend_idx == 6'd7);
                    cmd_resp = (fault == 1) ? 32'h0000_0880 : 32'h0000_0900;
                    if (pend_idx == 6'd6) begin
                        busy_cnt = 5; card_busy = 1'b1;
                        if (fault == 3) stuck = 1'b1;
                    end
                end
            end
            if (cmd_start) begin
                if (log_n < 16) begin
                    log_idx[log_n] = cmd_idx; log_arg[log_n] = cmd_arg; log_clk[log_n] = clk_sel;
                end
                log_n++;
                if (cmd_idx == 6'd13 && card_busy) busy_at_stat++;
                pend_idx = cmd_idx; lat_cnt = 3;
            end
            if (tune_cnt > 0) begin
                tune_cnt--;
                if (tune_cnt == 0) begin tune_done = 1'b1; tune_err = (fault == 2); end
            end else if (tune_req) begin
                tune_cnt = 4; tune_clk = clk_sel;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] swa(input logic [7:0] idx, input logic [7:0] val);
        return {6'b0, 2'b11, idx, val, 8'h00};
    endfunction

    task automatic add_exp(input logic [5:0] i, input logic [31:0] a, input logic [1:0] c);
        exp_idx[exp_n] = i; exp_arg[exp_n] = a; exp_clk[exp_n] = c; exp_n++;
    endtask

    task automatic build_exp(input vec_t v);
        logic [3:0] s;
        s = v.skip ? 4'd0 : v.drv;
        exp_n = 0;
        add_exp(6'd7, {RCA, 16'h0}, 2'd0);                       // R1
        if (v.outcome != 2'd0) return;
        add_exp(6'd6, swa(8'd185, {s, 4'd2}), 2'd0);             // R4 R5
        add_exp(6'd13, {RCA, 16'h0}, 2'd0);                      // R9
        if (!v.legacy) begin                                     // R6
            add_exp(6'd6, swa(8'd185, {s, 4'd1}), 2'd2);
            add_exp(6'd13, {RCA, 16'h0}, 2'd2);
            add_exp(6'd6, swa(8'd183, 8'h06), 2'd1);
            add_exp(6'd13, {RCA, 16'h0}, 2'd1);
            add_exp(6'd6, swa(8'd185, {s, 4'd3}), 2'd1);
            add_exp(6'd13, {RCA, 16'h0}, 2'd1);
        end else begin                                           // R8
            add_exp(6'd6, swa(8'd185, {s, 4'd3}), 2'd2);
            add_exp(6'd13, {RCA, 16'h0}, 2'd2);
        end
    endtask

    task automatic pulse_start(input vec_t v);
        dev_type = v.dev; drv_caps = v.caps; fault = int'(v.fault);
        stuck = 1'b0; log_n = 0; rd197 = 0; busy_at_stat = 0; tune_clk = 2'd3;
        @(negedge clk);
        start = 1'b1; legacy_seq = v.legacy; skip_drv_rd = v.skip; drv_sel = v.drv;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int k);
        logic [1:0] got;
        int n;
        build_exp(v);
        pulse_start(v);
        chk(!done && !unsupported && !error, "R10 start clears flags", {29'b0, done, unsupported, error}, 32'h0);
        n = 0;
        while (!(done || unsupported || error) && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) chk(1'b0, "watchdog run", k, 0);
        got = done ? 2'd0 : unsupported ? 2'd1 : error ? 2'd2 : 2'd3;
        chk(got == v.outcome, v.outcome == 2'd1 ? "R2 R3 outcome" : v.outcome == 2'd2 ? "R10 outcome" : "R7 outcome",
            got, v.outcome);
        if (v.outcome != 2'd2) begin
            chk(log_n == exp_n, "R1 R2 command count", log_n, exp_n);
            for (int i = 0; i < exp_n && i < log_n; i++) begin
                chk(log_idx[i] == exp_idx[i] && log_arg[i] == exp_arg[i],
                    i < 3 ? "R1 R4 command" : (v.legacy ? "R8 R4 command" : "R6 R4 command"),
                    log_arg[i] ^ {26'b0, log_idx[i]}, exp_arg[i] ^ {26'b0, exp_idx[i]});
                chk(log_clk[i] == exp_clk[i], "R11 clock at issue", log_clk[i], exp_clk[i]);
            end
            chk(rd197 == ((v.skip || v.dev[7:6] == 2'b00) ? 0 : 1), "R3 strength read", rd197,
                (v.skip || v.dev[7:6] == 2'b00) ? 0 : 1);
        end
        if (v.outcome == 2'd0) begin
            chk(clk_sel == 2'd2 && ddr8 && phy_timing == 2'd3, "R7 final mode",
                {27'b0, clk_sel, ddr8, phy_timing}, {27'b0, 2'd2, 1'b1, 2'd3});
            chk(tune_clk == 2'd2, "R5 tuning clock", tune_clk, 2'd2);
            chk(busy_at_stat == 0, "R9 status while busy", busy_at_stat, 0);
        end
        if (v.outcome == 2'd2) begin
            repeat (20) @(negedge clk);
            chk(error && !done, "R10 error sticky", {30'b0, error, done}, 32'h2);
        end
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(clk_sel == 0 && !ddr8 && phy_timing == 0 && !cmd_start && !tune_req && !done && !unsupported && !error,
            "R12 reset state", {24'b0, clk_sel, ddr8, phy_timing, cmd_start, tune_req, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_start && !done && !unsupported && !error, "R12 idle after reset",
            {28'b0, cmd_start, done, unsupported, error}, 32'h0);
        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // Start again after an error: the run must complete cleanly.
        run_vec(VECS[0], 100);

        // Reset while tuning is requested.
        pulse_start(VECS[1]);
        begin
            int n = 0;
            while (!tune_req && n < 2000) begin @(negedge clk); n++; end
        end
        chk(tune_req && clk_sel == 2'd2, "R5 tuning requested at target", {30'b0, tune_req, clk_sel[1]}, 32'h3);
        rst_n = 1'b0;
        @(negedge clk);
        chk(clk_sel == 0 && !ddr8 && phy_timing == 0 && !tune_req && !cmd_start && !error && !done,
            "R12 mid-run reset", {25'b0, clk_sel, ddr8, phy_timing, tune_req, cmd_start}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule